// File: doc/BRIEF.md
# Binary-Input Neural Sub-Network Engine

This block scores one class of a binary-image classifier. It evaluates a two-layer network: a hidden layer with a configurable number of neurons (2 to 10), fed by binary pixels and signed 13-bit weights, followed by a single output neuron. Each layer's result passes through a sigmoid lookup. The final 10-bit value is the class score. Several copies run side by side, one per class, and a neighbouring block compares their scores.

The engine has ten multiply-accumulate lanes. A weight multiplied by a binary pixel is just that weight, gated by the pixel. When fewer hidden neurons are configured, idle lanes are grouped so that one neuron takes several pixels per cycle. This shortens the image pass from one group per pixel to one group per 2, 3 or 5 pixels.

Biases and output-layer weights are loaded through a small register-write port while the engine is idle. A start pulse latches the hidden-neuron count and the image length. The engine then consumes pixel groups while `grpValid` is high, applies the sigmoid to each hidden sum through one shared lookup, forms the output sum, looks it up again, and raises `done` for one cycle with the new score.

Top module: `subnet_engine`

## Requirements
- R1: After reset, `done` is 0 and `score` is 0.
- R2: The hidden count is the `hidCount` value clamped to 2..10 and latched at start. The group size g is 5 for 2 neurons, 3 for 3, 2 for 4 or 5, and 1 for 6 or more. Lane l occupies `grpWeight` bits [13l+12:13l] and serves neuron floor(l/g) at pixel position l mod g. Lanes whose neuron is at or above the hidden count have no effect.
- R3: The pixel count is `pixCount` clamped to 1024. Bit p of `grpPix` in accepted group c is pixel c*g+p. A group is accepted only in a cycle with `grpValid` high. ceil(count/g) groups are accepted. Positions at or beyond the count are ignored.
- R4: The hidden sum of neuron n is its bias plus the sum of its weights at set pixels, saturated to the signed 13-bit range [-4096, 4095], where 256 stands for 1.0.
- R5: An activation is clamp(512 + floor(arg/4), 0, 1023) for a saturated argument arg.
- R6: The score is the activation of the output argument. The output argument is the output bias plus floor(sum over active neurons of outWeight_n * act_n / 1024), saturated as in R4.
- R7: `done` is a one-cycle pulse, high exactly h+4 cycles after the clock edge that accepted the last group, where h is the hidden count. `score` takes its new value in that same cycle and holds it otherwise.
- R8: With a pixel count of 0, no group is accepted, every hidden sum equals its bias, and `done` is high h+5 cycles after the edge that sampled start.
- R9: `start` is ignored while a computation is in progress.
- R10: With `loadWe` high, `loadSel` 0 writes hidden bias `loadIdx`, 1 writes output weight `loadIdx`, and 2 writes the output bias. Loads made while idle apply to the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled when idle) |
| hidCount | input | 4 | Requested hidden-neuron count |
| pixCount | input | 11 | Image length in pixels |
| grpValid | input | 1 | Pixel group and weights are present |
| grpPix | input | 5 | Pixel group, bit p is position p |
| grpWeight | input | 130 | Ten 13-bit signed lane weights |
| loadWe | input | 1 | Register load strobe |
| loadSel | input | 2 | Load target: hidden bias, output weight, output bias |
| loadIdx | input | 4 | Neuron index of the load |
| loadData | input | 13 | Signed load value |
| done | output | 1 | One-cycle completion pulse |
| score | output | 10 | Class score |

## Verification
Almost every internal fault surfaces only as a wrong `score` at the `done` pulse, which comes at the end of the whole image. Faults of this kind include a mis-mapped lane, a missed pixel gate, a lost saturation or a shifted activation capture. Each image is therefore built so that a fault changes the final score: padding positions and idle lanes carry large weights, and gap cycles carry all-ones pixels. Sequencing faults show sooner. A wrong group count or sigmoid walk moves `done` by whole cycles, and the bench sees this on the very next clock, because it compares `done` and `score` every cycle against its own behavioural model.

// File: rtl/subnet_pkg.sv
package subnet_pkg;
  parameter int LANES   = 10;
  parameter int W_W     = 13;
  parameter int SIG_W   = 10;
  parameter int MAX_GRP = 5;
  parameter int MAX_PIX = 1024;
  localparam int PIX_CW = $clog2(MAX_PIX + 1);
  localparam int HID_W  = $clog2(LANES + 1);
  localparam int GRP_W  = $clog2(MAX_GRP + 1);
  localparam int ACC_W  = W_W + PIX_CW;
  localparam int ARG_MAX = (1 <<< (W_W - 1)) - 1;
  localparam int SIG_MAX = (1 <<< SIG_W) - 1;

  typedef struct packed {
    logic preload;
    logic accum;
    logic sigIssue;
    logic outSum;
    logic outIssue;
    logic finish;
  } strobe_t;

  typedef enum logic [1:0] {LD_HBIAS = 2'd0, LD_OWGT = 2'd1, LD_OBIAS = 2'd2} load_sel_e;

  function automatic logic signed [W_W-1:0] satArg(input int v);
    if (v > ARG_MAX) return W_W'(ARG_MAX);
    else if (v < -ARG_MAX - 1) return W_W'(-ARG_MAX - 1);
    else return W_W'(v);
  endfunction

  function automatic logic [SIG_W-1:0] sigmoidOf(input logic signed [W_W-1:0] a);
    int v;
    v = (1 <<< (SIG_W - 1)) + (int'(a) >>> 2);
    if (v < 0) v = 0;
    if (v > SIG_MAX) v = SIG_MAX;
    return SIG_W'(v);
  endfunction

  function automatic logic [HID_W-1:0] clampHid(input logic [HID_W-1:0] h);
    if (h < HID_W'(2)) return HID_W'(2);
    else if (h > HID_W'(LANES)) return HID_W'(LANES);
    else return h;
  endfunction

  function automatic logic [GRP_W-1:0] groupSizeOf(input logic [HID_W-1:0] h);
    int g;
    g = LANES / int'(h);
    if (g > MAX_GRP) g = MAX_GRP;
    return GRP_W'(g);
  endfunction

  function automatic logic [HID_W-1:0] laneNeuron(input int lane, input logic [GRP_W-1:0] g);
    int r;
    case (g)
      GRP_W'(5): r = lane / 5;
      GRP_W'(3): r = lane / 3;
      GRP_W'(2): r = lane / 2;
      default:   r = lane;
    endcase
    return HID_W'(r);
  endfunction
endpackage

// File: rtl/sigmoid_rom.sv
module sigmoid_rom
  import subnet_pkg::*;
(
  input  logic                  clk,
  input  logic signed [W_W-1:0] addr,
  output logic [SIG_W-1:0]      data
);
  always_ff @(posedge clk) data <= sigmoidOf(addr);
endmodule

// File: rtl/subnet_ctrl.sv
module subnet_ctrl
  import subnet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [HID_W-1:0]  hidCountIn,
  input  logic [PIX_CW-1:0] pixCountIn,
  input  logic              grpValid,
  output strobe_t           strb,
  output logic [HID_W-1:0]  hidCnt,
  output logic [GRP_W-1:0]  grpSize,
  output logic [PIX_CW-1:0] pixLeft,
  output logic [HID_W-1:0]  sigIdx,
  output logic              done
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ACC, S_SIG, S_SIGW, S_OSUM, S_OSIG, S_FIN} state_e;
  state_e state;
  logic lastGrp;
  logic [HID_W-1:0] hidNext;

  assign lastGrp = pixLeft <= PIX_CW'(grpSize);
  assign hidNext = clampHid(hidCountIn);

  always_comb begin
    strb          = '0;
    strb.preload  = state == S_LOAD;
    strb.accum    = (state == S_ACC) && grpValid;
    strb.sigIssue = state == S_SIG;
    strb.outSum   = state == S_OSUM;
    strb.outIssue = state == S_OSIG;
    strb.finish   = state == S_FIN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      hidCnt  <= HID_W'(2);
      grpSize <= GRP_W'(MAX_GRP);
      pixLeft <= '0;
      sigIdx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= state == S_FIN;
      case (state)
        S_IDLE: if (start) begin
          hidCnt  <= hidNext;
          grpSize <= groupSizeOf(hidNext);
          pixLeft <= (pixCountIn > PIX_CW'(MAX_PIX)) ? PIX_CW'(MAX_PIX) : pixCountIn;
          state   <= S_LOAD;
        end
        S_LOAD: begin
          sigIdx <= '0;
          state  <= (pixLeft == '0) ? S_SIG : S_ACC;
        end
        S_ACC: if (grpValid) begin
          pixLeft <= lastGrp ? '0 : pixLeft - PIX_CW'(grpSize);
          if (lastGrp) state <= S_SIG;
        end
        S_SIG: begin
          sigIdx <= sigIdx + 1'b1;
          if (sigIdx == hidCnt - 1'b1) state <= S_SIGW;
        end
        S_SIGW:  state <= S_OSUM;
        S_OSUM:  state <= S_OSIG;
        S_OSIG:  state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R3
  pix_left_chk: assert property (@(posedge clk) disable iff (!rstN) strb.accum |-> pixLeft != '0);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && start) |=> $stable(hidCnt));
  // R2
  hid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (hidCnt >= HID_W'(2) && hidCnt <= HID_W'(LANES)));
endmodule

// File: rtl/subnet_datapath.sv
module subnet_datapath
  import subnet_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [HID_W-1:0]       hidCnt,
  input  logic [GRP_W-1:0]       grpSize,
  input  logic [PIX_CW-1:0]      pixLeft,
  input  logic [HID_W-1:0]       sigIdx,
  input  logic [MAX_GRP-1:0]     grpPix,
  input  logic [LANES*W_W-1:0]   grpWeight,
  input  logic                   loadWe,
  input  logic [1:0]             loadSel,
  input  logic [HID_W-1:0]       loadIdx,
  input  logic [W_W-1:0]         loadData,
  output logic [SIG_W-1:0]       score
);
  logic signed [W_W-1:0]   hidBias [LANES];
  logic signed [W_W-1:0]   outWgt  [LANES];
  logic signed [W_W-1:0]   outBias;
  logic signed [ACC_W-1:0] accView [LANES];
  logic [HID_W-1:0]        laneN   [LANES];
  logic [GRP_W-1:0]        laneP   [LANES];
  logic [SIG_W-1:0]        hidAct  [LANES];
  logic signed [W_W-1:0]   romAddr, outArg;
  logic [SIG_W-1:0]        romData;
  logic                    capValid;
  logic [HID_W-1:0]        capIdx;
  int                      neuronSum, prodSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LANES; k++) begin
        hidBias[k] <= '0;
        outWgt[k]  <= '0;
      end
      outBias <= '0;
    end else if (loadWe) begin
      case (loadSel)
        LD_HBIAS: if (loadIdx < HID_W'(LANES)) hidBias[loadIdx] <= loadData;
        LD_OWGT:  if (loadIdx < HID_W'(LANES)) outWgt[loadIdx] <= loadData;
        LD_OBIAS: outBias <= loadData;
        default:  ;
      endcase
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneN[l] = laneNeuron(l, grpSize);
      laneP[l] = GRP_W'(l - int'(laneN[l]) * int'(grpSize));
    end
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic signed [ACC_W-1:0] acc;
    logic signed [W_W-1:0]   laneW;
    logic                    laneOn, pixOn;
    assign laneW  = $signed(grpWeight[gl*W_W +: W_W]);
    assign laneOn = laneN[gl] < hidCnt;
    assign pixOn  = (PIX_CW'(laneP[gl]) < pixLeft) && grpPix[laneP[gl]];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) acc <= '0;
      else if (strb.preload)
        acc <= (laneOn && laneP[gl] == '0) ? ACC_W'(hidBias[laneN[gl]]) : '0;
      else if (strb.accum && laneOn && pixOn)
        acc <= acc + ACC_W'(laneW);
    end
    assign accView[gl] = acc;
  end

  always_comb begin
    neuronSum = 0;
    for (int l = 0; l < LANES; l++)
      if (laneN[l] == sigIdx) neuronSum += int'(accView[l]);
    prodSum = 0;
    for (int k = 0; k < LANES; k++)
      if (HID_W'(k) < hidCnt) prodSum += int'(outWgt[k]) * int'(hidAct[k]);
  end

  assign romAddr = strb.outIssue ? outArg : satArg(neuronSum);

  sigmoid_rom i_sigmoid_rom (.clk(clk), .addr(romAddr), .data(romData));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capIdx   <= '0;
      outArg   <= '0;
      score    <= '0;
      for (int k = 0; k < LANES; k++) hidAct[k] <= '0;
    end else begin
      capValid <= strb.sigIssue;
      capIdx   <= sigIdx;
      if (capValid) hidAct[capIdx] <= romData;
      if (strb.outSum) outArg <= satArg(int'(outBias) + (prodSum >>> 10));
      if (strb.finish) score <= romData;
    end
  end

  // R5
  sig_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(romAddr) == '0) |-> (romData == SIG_W'(1 << (SIG_W - 1))));
  // R7
  score_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (score != $past(score)) |-> $past(strb.finish));
endmodule

// File: rtl/subnet_engine.sv
module subnet_engine
  import subnet_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [HID_W-1:0]     hidCount,
  input  logic [PIX_CW-1:0]    pixCount,
  input  logic                 grpValid,
  input  logic [MAX_GRP-1:0]   grpPix,
  input  logic [LANES*W_W-1:0] grpWeight,
  input  logic                 loadWe,
  input  logic [1:0]           loadSel,
  input  logic [HID_W-1:0]     loadIdx,
  input  logic [W_W-1:0]       loadData,
  output logic                 done,
  output logic [SIG_W-1:0]     score
);
  strobe_t           strb;
  logic [HID_W-1:0]  hidCnt, sigIdx;
  logic [GRP_W-1:0]  grpSize;
  logic [PIX_CW-1:0] pixLeft;

  subnet_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .hidCountIn(hidCount), .pixCountIn(pixCount),
    .grpValid(grpValid), .strb(strb), .hidCnt(hidCnt), .grpSize(grpSize),
    .pixLeft(pixLeft), .sigIdx(sigIdx), .done(done)
  );

  subnet_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hidCnt(hidCnt), .grpSize(grpSize),
    .pixLeft(pixLeft), .sigIdx(sigIdx), .grpPix(grpPix), .grpWeight(grpWeight),
    .loadWe(loadWe), .loadSel(loadSel), .loadIdx(loadIdx), .loadData(loadData),
    .score(score)
  );
endmodule

// File: tb/test_subnet_engine.sv
module test_subnet_engine;
  import subnet_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [HID_W-1:0] hidCount = '0;
  logic [PIX_CW-1:0] pixCount = '0;
  logic grpValid = 1'b0;
  logic [MAX_GRP-1:0] grpPix = '0;
  logic [LANES*W_W-1:0] grpWeight = '0;
  logic loadWe = 1'b0;
  logic [1:0] loadSel = '0;
  logic [HID_W-1:0] loadIdx = '0;
  logic [W_W-1:0] loadData = '0;
  logic done;
  logic [SIG_W-1:0] score;

  always #5 clk = ~clk;

  subnet_engine i_subnet_engine (
    .clk(clk), .rstN(rstN), .start(start), .hidCount(hidCount), .pixCount(pixCount),
    .grpValid(grpValid), .grpPix(grpPix), .grpWeight(grpWeight), .loadWe(loadWe),
    .loadSel(loadSel), .loadIdx(loadIdx), .loadData(loadData), .done(done), .score(score)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expDoneCyc = -100;
  int pendScore = 0;
  int curScore = 0;
  bit chkOn = 1'b0;
  int wConst = 0;
  int oScale = 1;
  int hb[10];
  int ow[10];
  int ob = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int satv(input int v);
    if (v > 4095) return 4095;
    if (v < -4096) return -4096;
    return v;
  endfunction

  function automatic int sigm(input int a);
    int v;
    v = 512 + (a >>> 2);
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  function automatic bit pixv(input int i, input int seed);
    return ((i * 7 + seed * 5 + i / 3) % 5) < 2;
  endfunction

  function automatic int wv(input int n, input int i, input int seed);
    if (wConst != 0) return wConst;
    return ((n * 131 + i * 29 + seed * 17) % 241) - 120;
  endfunction

  // reference compared on every clock: done pulse timing and score hold (R7)
  always @(negedge clk) begin
    bit expD;
    if (chkOn) begin
      expD = (cyc == expDoneCyc);
      if (expD) curScore = pendScore;
      checks++;
      if (done !== expD) begin
        errors++;
        $display("FAIL R7 done at cycle %0d: actual %0b expected %0b", cyc, done, expD);
      end
      checks++;
      if (score !== SIG_W'(curScore)) begin
        errors++;
        $display("FAIL R7 score at cycle %0d: actual %0d expected %0d", cyc, score, curScore);
      end
    end
  end

  task automatic loadReg(input int sel, input int idx, input int val);
    @(negedge clk);
    loadWe = 1'b1; loadSel = 2'(sel); loadIdx = HID_W'(idx); loadData = W_W'(val);
    @(posedge clk);
    @(negedge clk);
    loadWe = 1'b0;
  endtask

  // R10: selector 0 hidden bias, 1 output weight, 2 output bias
  task automatic loadAll(input int seed);
    for (int n = 0; n < 10; n++) begin
      hb[n] = ((n * 53 + seed * 7) % 201) - 100;
      ow[n] = satv((((n * 71 + seed * 13) % 301) - 150) * oScale);
      loadReg(0, n, hb[n]);
      loadReg(1, n, ow[n]);
    end
    ob = ((seed * 37) % 401) - 200;
    loadReg(2, 0, ob);
  endtask

  task automatic runImage(input int hIn, input int P, input int seed, input int gap,
                          input bit pad, input bit busyStart, input string tag);
    int h, g, pc, ngr, Ts, Ta, s, acc, o, expS;
    int act[10];
    h = (hIn < 2) ? 2 : ((hIn > 10) ? 10 : hIn);
    g = (h == 2) ? 5 : ((h == 3) ? 3 : ((h <= 5) ? 2 : 1));
    pc = (P > 1024) ? 1024 : P;
    acc = 0;
    for (int n = 0; n < h; n++) begin
      s = hb[n];
      for (int i = 0; i < pc; i++) if (pixv(i, seed)) s += wv(n, i, seed);
      act[n] = sigm(satv(s));
      acc += ow[n] * act[n];
    end
    o = ob + (acc >>> 10);
    expS = sigm(satv(o));
    pendScore = expS;

    @(negedge clk);
    start = 1'b1; hidCount = HID_W'(hIn); pixCount = PIX_CW'(P);
    @(posedge clk); #1; Ts = cyc;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    Ta = Ts + 1;
    ngr = (pc + g - 1) / g;
    for (int c = 0; c < ngr; c++) begin
      if (gap > 0 && (c % gap) == 1) begin
        @(negedge clk);
        start = 1'b0; grpValid = 1'b0; grpPix = '1;
        for (int l = 0; l < LANES; l++) grpWeight[l*W_W +: W_W] = W_W'(1777);
        @(posedge clk);
      end
      @(negedge clk);
      start = 1'b0;
      if (busyStart && c == 1) begin
        start = 1'b1; hidCount = HID_W'(7); pixCount = PIX_CW'(3);
      end
      grpValid = 1'b1;
      for (int p = 0; p < MAX_GRP; p++)
        grpPix[p] = (p < g && c * g + p < pc) ? pixv(c * g + p, seed) : pad;
      for (int l = 0; l < LANES; l++) begin
        int n, p, w;
        n = l / g; p = l % g;
        if (n < h && c * g + p < pc) w = wv(n, c * g + p, seed);
        else w = pad ? 1777 : 0;
        grpWeight[l*W_W +: W_W] = W_W'(w);
      end
      @(posedge clk); #1; Ta = cyc;
    end
    @(negedge clk);
    grpValid = 1'b0; start = 1'b0; grpPix = '0;
    expDoneCyc = Ta + h + 4;
    while (cyc <= expDoneCyc) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
    checks++;
    if (score !== SIG_W'(expS)) begin
      errors++;
      $display("FAIL %s final score h=%0d P=%0d: actual %0d expected %0d", tag, hIn, P, score, expS);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || score !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual done=%0b score=%0d expected done=0 score=0", done, score);
    end
    chkOn = 1'b1;

    loadAll(1);  runImage(10, 64, 1, 0, 0, 0, "R4");
    loadAll(2);  runImage(2, 64, 2, 0, 1, 0, "R2");
    loadAll(3);  runImage(3, 20, 3, 0, 1, 0, "R3");
    loadAll(4);  runImage(4, 17, 4, 3, 1, 0, "R3");
    loadAll(5);  runImage(5, 33, 5, 2, 1, 0, "R2");
    loadAll(6);  runImage(7, 40, 6, 0, 1, 0, "R2");
    loadAll(7);  runImage(10, 1100, 7, 0, 0, 0, "R3");
    wConst = 4000;  loadAll(8); runImage(2, 30, 8, 0, 0, 0, "R4");
    wConst = -4000; loadAll(9); runImage(6, 30, 9, 0, 0, 0, "R5");
    wConst = 0;
    oScale = 30; loadAll(10); runImage(8, 50, 10, 0, 0, 0, "R6");
    oScale = 1;
    loadAll(11); runImage(4, 0, 11, 0, 0, 0, "R8");
    loadAll(12); runImage(1, 25, 12, 0, 1, 0, "R2");
    runImage(15, 25, 12, 0, 1, 0, "R2");
    loadAll(13); runImage(3, 40, 13, 0, 1, 1, "R9");
    loadAll(14); runImage(5, 24, 14, 0, 0, 0, "R10");
    ob = ob + 900; loadReg(2, 0, ob);
    hb[0] = -300; loadReg(0, 0, hb[0]);
    runImage(5, 24, 14, 0, 0, 0, "R10");
    loadAll(15); runImage(2, 1, 15, 0, 1, 0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule